// File: doc/BRIEF.md
# Interrupt Status and Mask Unit

This block gathers the interrupt events of an SD/MMC host controller into one status word and turns them into a single interrupt line. Sixteen core event lines (command, data, FIFO, error and card-detect sources) and one SDIO interrupt line per card arrive as one-cycle pulses. Each pulse sets a sticky raw bit, whatever the mask says. Software clears a raw bit by writing 1 to it.

An 18-bit enable mask (1 = enabled) selects which raw bits reach the masked status. The OR of the masked bits, gated by a global enable, drives a registered interrupt output. Software reaches the mask, masked status, raw status and global enable through a small word-wide register port with a combinational read path.

Top module: `irq_status_unit`

## Requirements
- R1: Event input bit k (0..15) sets raw status bit k. The bit order is: 0 card detect, 1 response error, 2 command done, 3 data transfer over, 4 transmit FIFO request, 5 receive FIFO request, 6 response CRC, 7 data CRC, 8 response timeout, 9 data read timeout, 10 host starvation timeout, 11 FIFO under/overrun, 12 locked-write error, 13 start bit error, 14 auto command done, 15 end-bit error. The SDIO pulse for card c sets raw bit 16+c. A raw bit is set in the cycle after its pulse.
- R2: Raw bits are set whatever the value of the mask or the global enable, and stay set until cleared.
- R3: A write to address 2 clears every raw bit whose write-data bit is 1. Raw bits whose write-data bit is 0 keep their value.
- R4: If an event and a write-1 clear hit the same bit in the same cycle, the bit ends up set.
- R5: The masked status equals raw AND mask, where mask bit 1 enables the bit and 0 blocks it. This also holds for the SDIO bits 17:16. Mask and global enable reset to 0.
- R6: The interrupt output is a register. It takes the value (global enable AND OR of the masked status) one cycle after that value is formed.
- R7: While the global enable is 0, the interrupt output is 0 from the next cycle on.
- R8: After reset, raw status, mask, masked status, global enable and the interrupt output are all 0.
- R9: Register addresses are: 0 mask (read/write, bits 17:0); 1 masked status (read only); 2 raw status (read, write-1-clear); 3 control, with bit 0 as the global enable. Read data shows the addressed register zero-extended, and shows the new value in the cycle after a write.
- R10: A write to address 1 changes neither the raw status, the mask nor the global enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | 16 | Core event pulses, one bit per raw status bit |
| sdio_evt_i | input | 2 | SDIO interrupt pulses, one bit per card |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Read data of the addressed register |
| raw_status_o | output | 18 | Raw status |
| masked_status_o | output | 18 | Masked status |
| irq_o | output | 1 | Registered interrupt line |

## Verification
Two functions can fall in the same cycle: a new event setting a raw bit, and a software write-1 clear of that same bit. The bench forces this collision on purpose with a directed step. It also gets it often by chance in the random phase, where sparse event patterns overlap random clear writes. Each such cycle is judged against a bench model in which the set wins. The model also tracks the one-cycle lag of the interrupt line behind mask and enable changes made in the same step.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int unsigned CORE_W = 16;
  localparam int unsigned SDIO_W = 2;
  localparam int unsigned REG_W  = 32;

  typedef enum logic [1:0] {
    ADDR_MASK = 2'd0,
    ADDR_MSTS = 2'd1,
    ADDR_RAW  = 2'd2,
    ADDR_CTRL = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/irq_raw_reg.sv
module irq_raw_reg #(
  parameter int unsigned W = 18
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] raw_o
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic bit_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       bit_q <= 1'b0;
      else if (set_i[b]) bit_q <= 1'b1;   // set beats clear
      else if (clr_i[b]) bit_q <= 1'b0;
    end
    assign raw_o[b] = bit_q;
  end
endmodule

// File: rtl/irq_cfg_reg.sv
module irq_cfg_reg #(
  parameter int unsigned W = 18
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         mask_we_i,
  input  logic [W-1:0] mask_d_i,
  input  logic         en_we_i,
  input  logic         en_d_i,
  output logic [W-1:0] mask_o,
  output logic         en_o
);
  logic [W-1:0] mask_q;
  logic         en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
      en_q   <= 1'b0;
    end else begin
      if (mask_we_i) mask_q <= mask_d_i;
      if (en_we_i)   en_q   <= en_d_i;
    end
  end

  assign mask_o = mask_q;
  assign en_o   = en_q;
endmodule

// File: rtl/irq_out_gen.sv
module irq_out_gen #(
  parameter int unsigned W = 18
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] raw_i,
  input  logic [W-1:0] mask_i,
  input  logic         en_i,
  output logic [W-1:0] masked_o,
  output logic         irq_o
);
  logic irq_q;

  assign masked_o = raw_i & mask_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= en_i & (|masked_o);
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/irq_status_unit.sv
module irq_status_unit
  import irq_pkg::*;
#(
  parameter int unsigned N_CORE = CORE_W,
  parameter int unsigned N_SDIO = SDIO_W,
  parameter int unsigned DW     = REG_W
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [N_CORE-1:0]        evt_i,
  input  logic [N_SDIO-1:0]        sdio_evt_i,
  input  logic                     reg_we_i,
  input  logic [1:0]               reg_addr_i,
  input  logic [DW-1:0]            reg_wdata_i,
  output logic [DW-1:0]            reg_rdata_o,
  output logic [N_CORE+N_SDIO-1:0] raw_status_o,
  output logic [N_CORE+N_SDIO-1:0] masked_status_o,
  output logic                     irq_o
);
  localparam int unsigned SW  = N_CORE + N_SDIO;
  localparam int unsigned PAD = DW - SW;

  logic [SW-1:0] set_all, clr_all, raw, mask, masked;
  logic          en;
  logic          wr_raw, wr_mask, wr_ctrl;

  assign set_all = {sdio_evt_i, evt_i};
  assign wr_raw  = reg_we_i && (reg_addr_i == ADDR_RAW);
  assign wr_mask = reg_we_i && (reg_addr_i == ADDR_MASK);
  assign wr_ctrl = reg_we_i && (reg_addr_i == ADDR_CTRL);
  assign clr_all = wr_raw ? reg_wdata_i[SW-1:0] : '0;

  irq_raw_reg #(.W(SW)) u_raw (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (set_all),
    .clr_i  (clr_all),
    .raw_o  (raw)
  );

  irq_cfg_reg #(.W(SW)) u_cfg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .mask_we_i (wr_mask),
    .mask_d_i  (reg_wdata_i[SW-1:0]),
    .en_we_i   (wr_ctrl),
    .en_d_i    (reg_wdata_i[0]),
    .mask_o    (mask),
    .en_o      (en)
  );

  irq_out_gen #(.W(SW)) u_out (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .raw_i    (raw),
    .mask_i   (mask),
    .en_i     (en),
    .masked_o (masked),
    .irq_o    (irq_o)
  );

  always_comb begin
    unique case (reg_addr_i)
      ADDR_MASK: reg_rdata_o = {{PAD{1'b0}}, mask};
      ADDR_MSTS: reg_rdata_o = {{PAD{1'b0}}, masked};
      ADDR_RAW:  reg_rdata_o = {{PAD{1'b0}}, raw};
      default:   reg_rdata_o = {{(DW-1){1'b0}}, en};
    endcase
  end

  assign raw_status_o    = raw;
  assign masked_status_o = masked;
endmodule

// File: rtl/irq_status_unit_chk.sv
module irq_status_unit_chk #(
  parameter int unsigned SW = 18,
  parameter int unsigned DW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [SW-1:0] set_all,
  input logic          reg_we_i,
  input logic [1:0]    reg_addr_i,
  input logic [DW-1:0] reg_wdata_i,
  input logic [SW-1:0] raw_status_o,
  input logic [SW-1:0] masked_status_o,
  input logic [SW-1:0] mask,
  input logic          en,
  input logic          irq_o
);
  assert_set_sticky_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((raw_status_o & $past(set_all)) == $past(set_all)));

  assert_w1c_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == 2'd2)
      |=> ((raw_status_o & $past(reg_wdata_i[SW-1:0] & ~set_all)) == '0));

  assert_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(reg_we_i && reg_addr_i == 2'd2) && set_all == '0) |=> $stable(raw_status_o));

  assert_irq_lag_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (irq_o == $past(en && (|masked_status_o))));

  assert_gate_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en |=> !irq_o);

  assert_ro_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == 2'd1) |=> ($stable(mask) && $stable(en)));
endmodule

bind irq_status_unit irq_status_unit_chk #(.SW(SW), .DW(DW)) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .set_all         (set_all),
  .reg_we_i        (reg_we_i),
  .reg_addr_i      (reg_addr_i),
  .reg_wdata_i     (reg_wdata_i),
  .raw_status_o    (raw_status_o),
  .masked_status_o (masked_status_o),
  .mask            (mask),
  .en              (en),
  .irq_o           (irq_o)
);

// File: tb/irq_status_unit_tb_top.sv
`timescale 1ns/1ps
module irq_status_unit_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] evt_i = '0;
  logic [1:0]  sdio_evt_i = '0;
  logic        reg_we_i = 1'b0;
  logic [1:0]  reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic [17:0] raw_status_o, masked_status_o;
  logic        irq_o;

  int unsigned n_chk = 0, n_err = 0;
  bit          done = 1'b0;

  logic [17:0] m_raw = '0, m_mask = '0;
  logic        m_en = 1'b0, m_irq = 1'b0;

  always #2.5 clk_i = ~clk_i;

  irq_status_unit dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .evt_i(evt_i), .sdio_evt_i(sdio_evt_i),
    .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i),
    .reg_rdata_o(reg_rdata_o), .raw_status_o(raw_status_o),
    .masked_status_o(masked_status_o), .irq_o(irq_o)
  );

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_rd(input logic [1:0] a);
    case (a)
      2'd0:    return {14'd0, m_mask};
      2'd1:    return {14'd0, m_raw & m_mask};
      2'd2:    return {14'd0, m_raw};
      default: return {31'd0, m_en};
    endcase
  endfunction

  task automatic step(input logic [15:0] ev, input logic [1:0] sd, input logic we,
                      input logic [1:0] a, input logic [31:0] wd, input string tag);
    logic        irq_n;
    logic [17:0] clr;
    @(negedge clk_i);
    evt_i = ev; sdio_evt_i = sd; reg_we_i = we; reg_addr_i = a; reg_wdata_i = wd;
    @(posedge clk_i);
    irq_n = m_en & (|(m_raw & m_mask));
    clr   = (we && a == 2'd2) ? wd[17:0] : '0;
    m_raw = (m_raw & ~clr) | {sd, ev};
    if (we && a == 2'd0) m_mask = wd[17:0];
    if (we && a == 2'd3) m_en = wd[0];
    m_irq = irq_n;
    #1;
    check(tag,  "raw",    {14'd0, raw_status_o}, {14'd0, m_raw});
    check("R5", "masked", {14'd0, masked_status_o}, {14'd0, m_raw & m_mask});
    check("R6", "irq",    {31'd0, irq_o}, {31'd0, m_irq});
    check("R9", "rdata",  reg_rdata_o, exp_rd(a));
  endtask

  task automatic idle(input string tag);
    step('0, '0, 1'b0, 2'd2, '0, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [15:0] ev;
    logic [1:0]  sd;
    void'($urandom(32'd20240611));
    #1;
    // R8 reset state
    check("R8", "raw",    {14'd0, raw_status_o}, 32'd0);
    check("R8", "masked", {14'd0, masked_status_o}, 32'd0);
    check("R8", "irq",    {31'd0, irq_o}, 32'd0);
    reg_addr_i = 2'd3; #1;
    check("R8", "enable", reg_rdata_o, 32'd0);
    repeat (3) @(posedge clk_i);
    @(negedge clk_i) rst_ni = 1'b1;

    // R1 bit positions; mask 0 so also R2
    step(16'h0001, 2'b00, 1'b0, 2'd2, '0, "R1");
    step(16'h8000, 2'b00, 1'b0, 2'd2, '0, "R1");
    step(16'h0000, 2'b10, 1'b0, 2'd2, '0, "R1");
    step(16'h0004, 2'b01, 1'b0, 2'd2, '0, "R2");
    // mask everything, enable still 0
    step('0, '0, 1'b1, 2'd0, 32'h0003_FFFF, "R9");
    idle("R7"); idle("R7");
    check("R7", "irq gated", {31'd0, irq_o}, 32'd0);
    // enable
    step('0, '0, 1'b1, 2'd3, 32'h1, "R9");
    idle("R6");
    check("R6", "irq up", {31'd0, irq_o}, 32'd1);
    // write to read-only masked status
    step('0, '0, 1'b1, 2'd1, 32'hFFFF_FFFF, "R10");
    idle("R10");
    // write-0 no effect, write-1 clear
    step('0, '0, 1'b1, 2'd2, 32'h0, "R3");
    step('0, '0, 1'b1, 2'd2, 32'h0000_0001, "R3");
    check("R3", "bit0 cleared", {31'd0, raw_status_o[0]}, 32'd0);
    // same-cycle set and clear
    step(16'h8000, 2'b00, 1'b1, 2'd2, 32'h0000_8000, "R4");
    check("R4", "bit15 held", {31'd0, raw_status_o[15]}, 32'd1);
    step('0, 2'b10, 1'b1, 2'd2, 32'h0002_0000, "R4");
    // mask polarity
    step('0, '0, 1'b1, 2'd0, 32'h0, "R5");
    idle("R5");
    check("R5", "irq off", {31'd0, irq_o}, 32'd0);
    step('0, '0, 1'b1, 2'd0, 32'h0002_0000, "R5");
    idle("R5");
    check("R5", "sdio1 irq", {31'd0, irq_o}, 32'd1);
    // disable drops line next cycle
    step('0, '0, 1'b1, 2'd3, 32'h0, "R7");
    idle("R7");
    check("R7", "irq dropped", {31'd0, irq_o}, 32'd0);
    step('0, '0, 1'b1, 2'd2, 32'h0003_FFFF, "R3");

    for (int i = 0; i < 600; i++) begin
      ev = 16'($urandom) & 16'($urandom) & 16'($urandom);
      sd = 2'($urandom) & 2'($urandom);
      step(ev, sd, ($urandom % 3) != 0, 2'($urandom), $urandom, "R2");
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule